// File: doc/BRIEF.md
# SEC-DED Memory Word Codec

This block guards 64-bit memory words against soft errors with eight check bits, so each stored codeword is 72 bits wide. On the write path a purely combinational encoder produces the check bits from a parity-check matrix in which every column has an odd number of ones. The caller stores the data word together with those check bits in its own array.

On the read path the stored data and check bits come back with a read-valid strobe. The syndrome is formed with a second matrix. It equals the write matrix except that its top row covers all 72 codeword bits, so the top syndrome bit is the overall parity of the word. No extra parity bit is written, and no separate whole-word parity tree sits beside the syndrome logic. A nonzero syndrome with odd overall parity that matches a column marks a single error, which is then flipped. Any other nonzero syndrome is reported as uncorrectable. Corrected data and both flags are registered one cycle after the read strobe and come out together with a read-valid output.

Top module: `ecc_codec`

## Requirements
- R1: `wr_check_o[r]` is the XOR of the data bits whose write column has bit r set. Codeword position p < 64 is data bit p, and position 64+k is check bit k, whose column is the unit vector with bit k set. Data bit d takes the d-th column from the list of 8-bit values with odd weight of at least 3, sorted by weight first and then by numeric value.
- R2: A read of an unmodified codeword returns the stored data with both flags low.
- R3: A single flipped data bit is corrected in the returned data, with the single-error flag high and the double-error flag low.
- R4: A single flipped check bit raises the single-error flag and returns the stored data unchanged.
- R5: Any two flipped codeword bits raise the double-error flag, keep the single-error flag low and return the read data uncorrected.
- R6: A syndrome with odd overall parity that matches no column (for example, from some triple errors) raises the double-error flag, keeps the single-error flag low and returns the read data uncorrected.
- R7: Data, flags and `rd_valid_o` update on the clock edge after a cycle with `rd_valid_i` high. In a cycle with `rd_valid_i` low, `rd_valid_o` and both flags go low on the next edge and the data output holds its value.
- R8: While `rst_n` is low, `rd_valid_o`, both flags and `rd_data_o` are zero.
- R9: The two error flags are never high at the same time.
- R10: Every encoded codeword (data plus its check bits) has even overall parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data_i | input | 64 | Data word being written |
| wr_check_o | output | 8 | Check bits for `wr_data_i` (combinational) |
| rd_valid_i | input | 1 | Read word present this cycle |
| rd_data_i | input | 64 | Data bits read from the array |
| rd_check_i | input | 8 | Check bits read from the array |
| rd_valid_o | output | 1 | Registered read result valid |
| rd_data_o | output | 64 | Corrected (or passed-through) data |
| rd_single_o | output | 1 | Single error found and corrected |
| rd_double_o | output | 1 | Uncorrectable error found |

## Verification
The hardest case to reach is an odd-parity syndrome that matches no column. No single or double error can produce it; only some three-bit errors can. The bench rebuilds the column set on its own and searches bit triples until the combined syndrome falls outside that set. It then injects that triple and expects the uncorrectable flag with the data passed through. Every single-bit position and 200 random distinct pairs are also injected on varied data patterns.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  // Number of ones in a value
  function automatic int popcnt(input logic [31:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  // Column of data bit d: d-th odd-weight (>=3) value, ordered by weight then value
  function automatic logic [31:0] data_col(input int cw, input int d);
    int cnt;
    cnt = 0;
    for (int w = 3; w <= cw; w += 2) begin
      for (int v = 0; v < (1 << cw); v++) begin
        if (popcnt(32'(v)) == w) begin
          if (cnt == d) return 32'(v);
          cnt++;
        end
      end
    end
    return 32'd0;
  endfunction

  // Write-matrix column for codeword position p (data first, then check bits)
  function automatic logic [31:0] write_col(input int dw, input int cw, input int p);
    if (p < dw) return data_col(cw, p);
    return 32'd1 << (p - dw);
  endfunction

  // Read-matrix column: the last row is forced to one everywhere
  function automatic logic [31:0] read_col(input int dw, input int cw, input int p);
    return write_col(dw, cw, p) | (32'd1 << (cw - 1));
  endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder #(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] check_o
);
  for (genvar r = 0; r < CW; r++) begin : g_row
    logic [DW-1:0] sel;
    for (genvar d = 0; d < DW; d++) begin : g_bit
      localparam logic [31:0] COL = ecc_pkg::write_col(DW, CW, d);
      assign sel[d] = data_i[d] & COL[r];
    end
    assign check_o[r] = ^sel;
  end
endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome #(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] check_i,
  output logic [CW-1:0] syn_o
);
  localparam int NW = DW + CW;
  logic [NW-1:0] word;
  assign word = {check_i, data_i};

  for (genvar r = 0; r < CW; r++) begin : g_row
    logic [NW-1:0] sel;
    for (genvar p = 0; p < NW; p++) begin : g_bit
      localparam logic [31:0] COL = ecc_pkg::read_col(DW, CW, p);
      assign sel[p] = word[p] & COL[r];
    end
    assign syn_o[r] = ^sel;
  end
endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector #(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input  logic [CW-1:0] syn_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          single_o,
  output logic          double_o
);
  localparam int NW = DW + CW;
  logic [NW-1:0] hit;
  logic          any_hit;
  logic          odd_par;
  logic          nonzero;

  for (genvar p = 0; p < NW; p++) begin : g_match
    localparam logic [31:0] RC = ecc_pkg::read_col(DW, CW, p);
    assign hit[p] = (syn_i == RC[CW-1:0]);
  end

  assign any_hit  = |hit;
  assign odd_par  = syn_i[CW-1];
  assign nonzero  = |syn_i;
  assign single_o = nonzero & odd_par & any_hit;
  assign double_o = nonzero & ~single_o;
  // Only a matched column flips a bit; check-bit matches leave data untouched
  assign data_o   = data_i ^ hit[DW-1:0];
endmodule

// File: rtl/ecc_codec.sv
module ecc_codec #(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data_i,
  output logic [CW-1:0] wr_check_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic [CW-1:0] rd_check_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_single_o,
  output logic          rd_double_o
);
  // Internal events, named for the assertions
  logic [CW-1:0] syn;
  logic [DW-1:0] fix_data;
  logic          ev_single;
  logic          ev_double;

  ecc_encoder #(.DW(DW), .CW(CW)) u_enc (
    .data_i (wr_data_i),
    .check_o(wr_check_o)
  );

  ecc_syndrome #(.DW(DW), .CW(CW)) u_syn (
    .data_i (rd_data_i),
    .check_i(rd_check_i),
    .syn_o  (syn)
  );

  ecc_corrector #(.DW(DW), .CW(CW)) u_fix (
    .syn_i   (syn),
    .data_i  (rd_data_i),
    .data_o  (fix_data),
    .single_o(ev_single),
    .double_o(ev_double)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
      rd_single_o <= 1'b0;
      rd_double_o <= 1'b0;
    end else begin
      rd_valid_o  <= rd_valid_i;
      rd_single_o <= rd_valid_i & ev_single;
      rd_double_o <= rd_valid_i & ev_double;
      if (rd_valid_i) rd_data_o <= fix_data;
    end
  end

  // R10: each encoded word has even overall parity
  p_even_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ^{wr_check_o, wr_data_i} == 1'b0);

  // R2: a zero syndrome means the data passes unchanged with no flag
  p_clean_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (syn == '0) |-> (!ev_single && !ev_double && fix_data == rd_data_i));

  // R3: single-error decisions only happen with odd overall parity
  p_single_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_single |-> syn[CW-1]);

  // R5: even-parity nonzero syndrome is always uncorrectable
  p_even_double_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (syn != '0 && !syn[CW-1]) |-> (ev_double && fix_data == rd_data_i));

  // R9: flags are exclusive
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_single_o && rd_double_o));

  // R7: output valid follows input valid by one cycle
  p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_i |=> rd_valid_o);

  // R7: idle cycles leave flags low and data held
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |=> (!rd_valid_o && !rd_single_o && !rd_double_o && $stable(rd_data_o)));
endmodule

// File: tb/tb_ecc_codec.sv
`timescale 1ns/1ps
module tb_ecc_codec;
  localparam int DW = 64;
  localparam int CW = 8;
  localparam int NW = DW + CW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] wr_data_i;
  logic [CW-1:0] wr_check_o;
  logic          rd_valid_i;
  logic [DW-1:0] rd_data_i;
  logic [CW-1:0] rd_check_i;
  logic          rd_valid_o;
  logic [DW-1:0] rd_data_o;
  logic          rd_single_o;
  logic          rd_double_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [CW-1:0] wcol [NW];
  logic [CW-1:0] rcol [NW];

  always #4 clk = ~clk;

  ecc_codec #(.DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_data_i(wr_data_i), .wr_check_o(wr_check_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .rd_check_i(rd_check_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .rd_single_o(rd_single_o), .rd_double_o(rd_double_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Column table built from popcounts, independent of the RTL package
  task automatic build_cols();
    int idx = 0;
    for (int w = 3; w <= CW; w += 2)
      for (int v = 0; v < 256; v++)
        if ($countones(v[7:0]) == w && idx < DW) begin
          wcol[idx] = v[7:0];
          idx++;
        end
    for (int k = 0; k < CW; k++) wcol[DW+k] = 8'(1 << k);
    for (int p = 0; p < NW; p++) rcol[p] = wcol[p] | 8'h80;
  endtask

  function automatic logic [CW-1:0] model_enc(input logic [DW-1:0] d);
    logic [CW-1:0] c = '0;
    for (int i = 0; i < DW; i++) if (d[i]) c ^= wcol[i];
    return c;
  endfunction

  // One read: inputs at negedge, sampled at the following negedge
  task automatic do_read(input logic [DW-1:0] d, input logic [CW-1:0] c, input string req,
                         input logic [DW-1:0] exp_d, input bit exp_s, input bit exp_dbl);
    @(negedge clk);
    rd_valid_i = 1'b1; rd_data_i = d; rd_check_i = c;
    @(negedge clk);
    rd_valid_i = 1'b0;
    chk(rd_valid_o == 1'b1, req, 64'(rd_valid_o), 64'd1);
    chk(rd_data_o == exp_d, req, rd_data_o, exp_d);
    chk({rd_single_o, rd_double_o} == {exp_s, exp_dbl}, req,
        64'({rd_single_o, rd_double_o}), 64'({exp_s, exp_dbl}));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rd_valid_i = 1'b0; rd_data_i = '0; rd_check_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    chk({rd_valid_o, rd_single_o, rd_double_o} == 3'b000 && rd_data_o == '0, "R8 reset",
        {61'd0, rd_valid_o, rd_single_o, rd_double_o} | rd_data_o, 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_encode();
    logic [DW-1:0] pats [5];
    pats[0] = '0; pats[1] = '1; pats[2] = 64'hA5A5_5A5A_F0F0_0F0F;
    pats[3] = 64'h8000_0000_0000_0001; pats[4] = {$urandom, $urandom};
    for (int i = 0; i < 5; i++) begin
      wr_data_i = pats[i];
      #1;
      chk(wr_check_o == model_enc(pats[i]), "R1 encode", 64'(wr_check_o), 64'(model_enc(pats[i])));
      chk(^{wr_check_o, wr_data_i} == 1'b0, "R10 parity", 64'(^{wr_check_o, wr_data_i}), 64'd0);
    end
    for (int b = 0; b < DW; b++) begin
      wr_data_i = 64'd1 << b;
      #1;
      chk(wr_check_o == wcol[b], "R1 column", 64'(wr_check_o), 64'(wcol[b]));
    end
  endtask

  task automatic t_clean();
    for (int i = 0; i < 6; i++) begin
      logic [DW-1:0] d = (i == 0) ? '0 : (i == 1) ? '1 : {$urandom, $urandom};
      do_read(d, model_enc(d), "R2 clean", d, 1'b0, 1'b0);
    end
  endtask

  task automatic t_single();
    for (int p = 0; p < NW; p++) begin
      logic [DW-1:0] d = {$urandom, $urandom};
      logic [NW-1:0] w = {model_enc(d), d};
      w[p] = ~w[p];
      do_read(w[DW-1:0], w[NW-1:DW], (p < DW) ? "R3 data flip" : "R4 check flip", d, 1'b1, 1'b0);
    end
  endtask

  task automatic t_double();
    for (int n = 0; n < 200; n++) begin
      int a = $urandom % NW;
      int b = (a + 1 + ($urandom % (NW - 1))) % NW;
      logic [DW-1:0] d = {$urandom, $urandom};
      logic [NW-1:0] w = {model_enc(d), d};
      w[a] = ~w[a]; w[b] = ~w[b];
      do_read(w[DW-1:0], w[NW-1:DW], "R5 double", w[DW-1:0], 1'b0, 1'b1);
    end
  endtask

  task automatic t_unmatched();
    bit found = 0;
    int fa = 0, fb = 0, fc = 0;
    for (int a = 0; a < NW && !found; a++)
      for (int b = a + 1; b < NW && !found; b++)
        for (int c = b + 1; c < NW && !found; c++) begin
          logic [CW-1:0] s = rcol[a] ^ rcol[b] ^ rcol[c];
          bit hit = 0;
          for (int p = 0; p < NW; p++) if (rcol[p] == s) hit = 1;
          if (!hit) begin found = 1; fa = a; fb = b; fc = c; end
        end
    chk(found, "R6 triple search", 64'(found), 64'd1);
    if (found) begin
      logic [DW-1:0] d = 64'h0123_4567_89AB_CDEF;
      logic [NW-1:0] w = {model_enc(d), d};
      w[fa] = ~w[fa]; w[fb] = ~w[fb]; w[fc] = ~w[fc];
      do_read(w[DW-1:0], w[NW-1:DW], "R6 unmatched", w[DW-1:0], 1'b0, 1'b1);
    end
  endtask

  task automatic t_timing();
    logic [DW-1:0] d = 64'hDEAD_BEEF_0BAD_F00D;
    logic [NW-1:0] w = {model_enc(d), d};
    w[5] = ~w[5];
    @(negedge clk);
    rd_valid_i = 1'b1; rd_data_i = w[DW-1:0]; rd_check_i = w[NW-1:DW];
    @(posedge clk); #1;
    chk(rd_valid_o && rd_single_o && rd_data_o == d, "R7 one-cycle latency", rd_data_o, d);
    @(negedge clk);
    rd_valid_i = 1'b0; rd_data_i = '1; rd_check_i = '0;
    @(posedge clk); #1;
    chk(!rd_valid_o && !rd_single_o && !rd_double_o, "R7 idle flags low",
        64'({rd_valid_o, rd_single_o, rd_double_o}), 64'd0);
    chk(rd_data_o == d, "R7 data held", rd_data_o, d);
    chk(!(rd_single_o && rd_double_o), "R9 exclusive flags", 64'({rd_single_o, rd_double_o}), 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    build_cols();
    t_reset();
    t_encode();
    t_clean();
    t_single();
    t_double();
    t_unmatched();
    t_timing();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule